// File: doc/BRIEF.md
# Sticky Error Status Register with Event Messaging

This block holds a 16-bit error status word with four event flags. The flags record a software-raised management interrupt event, a thermal trip, a locked access that landed outside DRAM, and a refresh backlog. Event pulses come from elsewhere in the chip. The refresh backlog is derived inside the block from a queue-depth input. Software reads the word on `rd_data` and acknowledges a flag by writing a 1 to its position.

When a flag goes from clear to set and its enable input is high, the block raises `msg_req` for one cycle. This pulse asks the chip's messaging logic to send a system-error notice. The flags are sticky: they survive a warm reset and are cleared only by a cold reset or by a software write. The thermal flag behaves differently from the others. It records a trip only when that trip was actually signalled, so a trip seen while its enable is low leaves no trace. A trip seen while the flag is already set is also dropped.

Top module: `err_status_block`

## Requirements
- R1: After cold reset `rd_data` is 0x0000. Bits 15:13, bit 10 and bits 7:0 always read 0, and writes to them have no effect.
- R2: Flag positions are fixed: bit 12 is the software event, bit 11 the thermal trip, bit 9 the non-DRAM lock and bit 8 the refresh timeout. `msg_en` is indexed bit 0 refresh timeout, bit 1 lock, bit 2 thermal, bit 3 software event.
- R3: The refresh-timeout flag sets at the clock edge where `refq_depth` is at least 1024. A depth of 1023 does not set it.
- R4: `msg_req` is high for the cycle after an edge at which some flag went from 0 to 1 with its enable high. A flag that is already 1 sends nothing on a repeat event.
- R5: The software, lock and refresh flags set on their event whether or not their enable is high.
- R6: While `wr_en` is high, a 1 in `wr_data` at a flag position clears that flag at the next edge. A 0 leaves the flag unchanged.
- R7: The thermal flag sets only when `therm_evt` arrives with `msg_en[2]` high and the flag clear. A thermal event with the enable low leaves the flag at 0 and sends no message.
- R8: If a set event and a clearing write hit the same flag in the same cycle, the flag stays or becomes 1.
- R9: Asserting `warm_rst_n` low keeps all flags. `cold_rst_n` low clears flags and `msg_req`.
- R10: While `warm_rst_n` is low, `msg_req` stays 0, but events still set their flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous cold reset, active low; clears everything |
| warm_rst_n | input | 1 | Synchronous warm reset, active low; quiets messages only |
| sw_smi_evt | input | 1 | Software management interrupt event pulse |
| therm_evt | input | 1 | Thermal trip event pulse |
| lock_evt | input | 1 | Locked access to non-DRAM target pulse |
| refq_depth | input | DEPTH_W (11) | Pending refresh count |
| msg_en | input | 4 | Per-flag message enables (see R2) |
| wr_en | input | 1 | Write strobe for clear-by-one |
| wr_data | input | 16 | Write data; 1 bits clear flags |
| rd_data | output | 16 | Status word |
| msg_req | output | 1 | One-cycle system-error message request |

## Verification
The hardest case to reach is a flag that is being set and cleared in the same cycle while it is already set. In that case the flag must remain at 1 and must not produce a second message. The bench reaches it by holding the refresh depth at the threshold, so the set condition stays true every cycle, and writing a clear to that bit at the same time. A second hard case is an event that arrives during warm reset. The bench pulses a lock event with warm reset held low, then confirms that the flag was recorded and that no message was issued.

// File: rtl/errsts_pkg.sv
package errsts_pkg;

    localparam int REG_W  = 16;
    localparam int NFLAG  = 4;

    // Flag indices; also the msg_en bit order
    localparam int FLG_REFTO = 0;
    localparam int FLG_LOCK  = 1;
    localparam int FLG_THERM = 2;
    localparam int FLG_SWSMI = 3;

    // Status-word bit position of each flag index
    function automatic int flag_pos(input int idx);
        case (idx)
            FLG_REFTO: return 8;
            FLG_LOCK:  return 9;
            FLG_THERM: return 11;
            default:   return 12;
        endcase
    endfunction

    // Flag index living at a status-word bit, or -1 if reserved
    function automatic int pos_to_flag(input int pos);
        for (int k = 0; k < NFLAG; k++) begin
            if (flag_pos(k) == pos) return k;
        end
        return -1;
    endfunction

    function automatic logic [REG_W-1:0] flag_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < NFLAG; k++) m[flag_pos(k)] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic flag;
    } cell_state_t;

    typedef struct packed {
        logic msg_req;
    } top_state_t;

endpackage

// File: rtl/errsts_flag_cell.sv
module errsts_flag_cell #(
    parameter bit GATE_ON_SEND = 1'b0
) (
    input  logic clk,
    input  logic cold_rst_n,
    input  logic evt,
    input  logic clr,
    input  logic send_en,
    output logic flag,
    output logic send
);
    import errsts_pkg::*;

    cell_state_t st_d, st_q;
    logic        set_ok;

    always_comb begin
        st_d = st_q;
        // A gated flag records only an event that is actually signalled
        if (GATE_ON_SEND) set_ok = evt && send_en && !st_q.flag;
        else              set_ok = evt;
        // Set has priority over a same-cycle clear
        if (set_ok)   st_d.flag = 1'b1;
        else if (clr) st_d.flag = 1'b0;
        send = set_ok && !st_q.flag && send_en;
    end

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) st_q <= '0;
        else             st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/errsts_refq_cmp.sv
module errsts_refq_cmp #(
    parameter int DEPTH_W = 11,
    parameter int LIMIT   = 1024
) (
    input  logic [DEPTH_W-1:0] depth,
    output logic               over
);
    localparam logic [DEPTH_W-1:0] LIMIT_V = DEPTH_W'(LIMIT);

    always_comb over = (depth >= LIMIT_V);

endmodule

// File: rtl/err_status_block.sv
module err_status_block #(
    parameter int DEPTH_W    = 11,
    parameter int REFQ_LIMIT = 1024
) (
    input  logic               clk,
    input  logic               cold_rst_n,
    input  logic               warm_rst_n,
    input  logic               sw_smi_evt,
    input  logic               therm_evt,
    input  logic               lock_evt,
    input  logic [DEPTH_W-1:0] refq_depth,
    input  logic [3:0]         msg_en,
    input  logic               wr_en,
    input  logic [15:0]        wr_data,
    output logic [15:0]        rd_data,
    output logic               msg_req
);
    import errsts_pkg::*;

    logic [NFLAG-1:0] evt_vec, clr_vec, flag_vec, send_vec;
    logic             refq_over;
    top_state_t       st_d, st_q;

    errsts_refq_cmp #(.DEPTH_W(DEPTH_W), .LIMIT(REFQ_LIMIT)) u_refq (
        .depth (refq_depth),
        .over  (refq_over)
    );

    always_comb begin
        evt_vec            = '0;
        evt_vec[FLG_REFTO] = refq_over;
        evt_vec[FLG_LOCK]  = lock_evt;
        evt_vec[FLG_THERM] = therm_evt;
        evt_vec[FLG_SWSMI] = sw_smi_evt;
    end

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        assign clr_vec[k] = wr_en && wr_data[flag_pos(k)];
        errsts_flag_cell #(.GATE_ON_SEND(k == FLG_THERM)) u_cell (
            .clk        (clk),
            .cold_rst_n (cold_rst_n),
            .evt        (evt_vec[k]),
            .clr        (clr_vec[k]),
            .send_en    (msg_en[k]),
            .flag       (flag_vec[k]),
            .send       (send_vec[k])
        );
    end

    for (genvar b = 0; b < REG_W; b++) begin : g_rd
        if (pos_to_flag(b) >= 0) begin : g_live
            assign rd_data[b] = flag_vec[pos_to_flag(b)];
        end else begin : g_rsvd
            // reserved position: reads zero, write data discarded
            assign rd_data[b] = 1'b0 & wr_data[b];
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.msg_req = warm_rst_n && (|send_vec);
    end

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) st_q <= '0;
        else             st_q <= st_d;
    end

    assign msg_req = st_q.msg_req;

endmodule

// File: rtl/errsts_chk.sv
module errsts_chk #(
    parameter int DEPTH_W    = 11,
    parameter int REFQ_LIMIT = 1024
) (
    input logic               clk,
    input logic               cold_rst_n,
    input logic               warm_rst_n,
    input logic               sw_smi_evt,
    input logic [DEPTH_W-1:0] refq_depth,
    input logic               wr_en,
    input logic [15:0]        wr_data,
    input logic [15:0]        rd_data,
    input logic               msg_req
);
    import errsts_pkg::*;

    localparam logic [15:0] FMASK = flag_mask();

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (rd_data & ~FMASK) == 16'h0);

    a_r4_msg_needs_rise: assert property (@(posedge clk) disable iff (!cold_rst_n)
        msg_req |-> ((rd_data & ~$past(rd_data)) != 16'h0));

    a_r7_therm_set_sent: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $rose(rd_data[11]) |-> msg_req);

    a_r3_refq_sets: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (refq_depth >= DEPTH_W'(REFQ_LIMIT)) |=> rd_data[8]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!cold_rst_n)
        sw_smi_evt |=> rd_data[12]);

    a_r10_warm_quiet: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !warm_rst_n |=> !msg_req);

    for (genvar k = 0; k < NFLAG; k++) begin : g_clr
        a_r6_clear_by_write: assert property (@(posedge clk) disable iff (!cold_rst_n)
            $fell(rd_data[flag_pos(k)]) |-> $past(wr_en && wr_data[flag_pos(k)]));
    end

endmodule

bind err_status_block errsts_chk #(.DEPTH_W(DEPTH_W), .REFQ_LIMIT(REFQ_LIMIT)) u_chk (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .sw_smi_evt (sw_smi_evt),
    .refq_depth (refq_depth),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .msg_req    (msg_req)
);

// File: tb/test_err_status_block.sv
module test_err_status_block;

    logic        clk = 1'b0;
    logic        cold_rst_n, warm_rst_n;
    logic        sw_smi_evt, therm_evt, lock_evt;
    logic [10:0] refq_depth;
    logic [3:0]  msg_en;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        msg_req;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    err_status_block i_err_status_block (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .sw_smi_evt(sw_smi_evt), .therm_evt(therm_evt), .lock_evt(lock_evt),
        .refq_depth(refq_depth), .msg_en(msg_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .msg_req(msg_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_state(input string req, input logic [15:0] rd, input logic msg);
        check(req, rd_data, rd);
        check(req, {15'h0, msg_req}, {15'h0, msg});
    endtask

    task automatic do_cold_reset();
        cold_rst_n = 1'b0;
        tick(); tick();
        cold_rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_cold_reset();
        expect_state("R1 reset", 16'h0000, 1'b0);
    endtask

    task automatic t_sw_event();
        msg_en = 4'b1111;
        sw_smi_evt = 1'b1; tick();
        expect_state("R2 R4 sw rise", 16'h1000, 1'b1);
        sw_smi_evt = 1'b0; tick();
        expect_state("R4 pulse one cycle", 16'h1000, 1'b0);
        sw_smi_evt = 1'b1; tick();
        expect_state("R4 repeat no msg", 16'h1000, 1'b0);
        sw_smi_evt = 1'b0;
    endtask

    task automatic t_lock_disabled();
        msg_en = 4'b1101;
        lock_evt = 1'b1; tick();
        expect_state("R5 lock sets with enable low", 16'h1200, 1'b0);
        lock_evt = 1'b0;
        msg_en = 4'b1111;
    endtask

    task automatic t_w1c();
        wr_en = 1'b1;
        wr_data = 16'h1000; tick();
        expect_state("R6 clear bit12", 16'h0200, 1'b0);
        wr_data = 16'h0000; tick();
        expect_state("R6 write zero", 16'h0200, 1'b0);
        wr_data = 16'hE4FF; tick();
        expect_state("R1 reserved write", 16'h0200, 1'b0);
        wr_data = 16'h0200; tick();
        expect_state("R6 clear bit9", 16'h0000, 1'b0);
        wr_en = 1'b0; wr_data = 16'h0;
    endtask

    task automatic t_thermal();
        msg_en = 4'b1011;
        therm_evt = 1'b1; tick();
        expect_state("R7 therm disabled", 16'h0000, 1'b0);
        msg_en = 4'b1111; tick();
        expect_state("R7 therm enabled", 16'h0800, 1'b1);
        tick();
        expect_state("R7 therm repeat dropped", 16'h0800, 1'b0);
        therm_evt = 1'b0;
    endtask

    task automatic t_refresh();
        refq_depth = 11'd1023; tick();
        expect_state("R3 depth 1023", 16'h0800, 1'b0);
        refq_depth = 11'd1024; tick();
        expect_state("R3 depth 1024", 16'h0900, 1'b1);
        wr_en = 1'b1; wr_data = 16'h0100; tick();
        expect_state("R8 set beats clear", 16'h0900, 1'b0);
        refq_depth = 11'd0; tick();
        expect_state("R6 refto cleared", 16'h0800, 1'b0);
        wr_en = 1'b0; wr_data = 16'h0;
    endtask

    task automatic t_warm();
        warm_rst_n = 1'b0; tick();
        expect_state("R9 warm keeps flags", 16'h0800, 1'b0);
        lock_evt = 1'b1; tick();
        expect_state("R10 event under warm", 16'h0A00, 1'b0);
        lock_evt = 1'b0; warm_rst_n = 1'b1; tick();
        expect_state("R9 after warm", 16'h0A00, 1'b0);
        do_cold_reset();
        expect_state("R9 cold clears", 16'h0000, 1'b0);
        sw_smi_evt = 1'b1; tick();
        expect_state("R4 after cold", 16'h1000, 1'b1);
        sw_smi_evt = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        cold_rst_n = 1'b0; warm_rst_n = 1'b1;
        sw_smi_evt = 1'b0; therm_evt = 1'b0; lock_evt = 1'b0;
        refq_depth = '0; msg_en = 4'b1111; wr_en = 1'b0; wr_data = '0;
        t_reset();
        t_sw_event();
        t_lock_disabled();
        t_w1c();
        t_thermal();
        t_refresh();
        t_warm();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule